// File: doc/BRIEF.md
# I2C Write-Only Master Controller

This block is a single-master I2C controller that performs write transfers to slaves with 7-bit addresses. Software works through four byte-wide registers: control, status, a one-byte transmit holding register and a clock divider. The holding register is separate from the shift register that drives SDA. Software can therefore load the next byte while the current one is still on the wire. The controller generates START, the address byte, data bytes, the acknowledge clock and STOP on open-drain SCL and SDA lines. It records whether each byte was acknowledged and raises one interrupt line for "holding register empty" and for "slave did not acknowledge".

The transmit engine is a state machine that advances only on quarter-period ticks of SCL. The states are `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_ACK`, `ST_HOLD`, `ST_NACK` and `ST_STOP`, and the transitions between them are these:
- `ST_IDLE` to `ST_START`: the block is enabled, the START bit is set and a byte is waiting.
- `ST_START` to `ST_DATA`: after three quarters, and the first byte is loaded.
- `ST_DATA` to `ST_ACK`: after the eighth bit.
- `ST_ACK` to `ST_NACK`: SDA was sampled high.
- `ST_ACK` to `ST_STOP`: the byte was acknowledged and STOP is pending.
- `ST_ACK` to `ST_DATA`: the byte was acknowledged and a byte is waiting. The shift register reloads.
- `ST_ACK` to `ST_HOLD`: the byte was acknowledged and no byte is waiting.
- `ST_HOLD` to `ST_DATA` or `ST_STOP`: software writes a byte or sets STOP.
- `ST_NACK` to `ST_STOP`: software sets STOP.
- `ST_STOP` to `ST_IDLE`: after three quarters. The engine then clears STOP and the NACK flag.
- `ST_IDLE` with STOP set: STOP is cleared at once and the bus is untouched.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, control (address 0) reads 0x00 and status (address 1) reads 0x01. Status bit 0 is TDRE, bit 1 is ACK and bit 2 is NACK. SCL and SDA are both released and `irq` is low.
- R2: Control bits are: bit 0 enable, bit 1 transmit-interrupt enable, bit 2 START, bit 3 STOP, bit 4 FLUSH. Address 2 is the data register and address 3 the divider. `irq` equals enable AND ((transmit-interrupt enable AND TDRE) OR NACK). Writing the data register clears TDRE.
- R3: With the block enabled, START set and a byte waiting, SDA falls while SCL is high, and the START bit then clears. With START set but no byte waiting, the bus stays idle and START stays set.
- R4: Each byte goes out MSB first. SDA changes only while SCL is low, except for START and STOP. Within a byte, SCL rising edges are 4*(divider+1) clocks apart.
- R5: TDRE sets once the first bit of a byte has been clocked onto the bus: after that bit's SCL rising edge and before the second one.
- R6: The acknowledge is sampled while SCL is high in the ninth clock. Low sets ACK, and the next byte is then reloaded from the data register into the shift register.
- R7: SDA high in the ninth clock clears ACK, sets NACK and raises `irq`. SCL is then held low and no STOP is sent until software sets STOP.
- R8: Writing STOP with FLUSH makes the controller send a STOP condition and then clear STOP and NACK by itself. FLUSH reads back 1 for one cycle after the write and 0 after that. TDRE is set on the edge after the write.
- R9: A STOP requested while a byte is being shifted is sent only after that byte's acknowledge clock.
- R10: If the data register is empty when an acknowledged byte ends and STOP is not set, SCL stays low and nothing is sent until software writes data.
- R11: FLUSH discards a waiting byte, so a later START request finds no data and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt: transmit-empty or not-acknowledged |
| scl_oe | output | 1 | Pulls SCL low when high |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pulls SDA low when high |
| sda_in | input | 1 | SDA line level |

## Verification
A register write takes effect at the clock edge on which it is sampled, and status and `irq` are readable on the following falling edge. FLUSH is the exception: it empties the data register one edge later. Bus events are tied to quarter ticks of divider+1 clocks, so the bench records edges with a cycle-stamped slave model and compares SCL spacing against 4*(divider+1). TDRE is polled on every falling edge, and the slave's bit count at the first sighting pins the one-bit window of R5. Hold and NACK waits are checked after a fixed idle stretch, before any further stimulus.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int C_EN    = 0;
    localparam int C_TXIE  = 1;
    localparam int C_START = 2;
    localparam int C_STOP  = 3;
    localparam int C_FLUSH = 4;

    localparam int S_TDRE = 0;
    localparam int S_ACK  = 1;
    localparam int S_NACK = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ACK,
        ST_HOLD,
        ST_NACK,
        ST_STOP
    } eng_state_t;
endpackage

// File: rtl/i2c_wr_tick.sv
module i2c_wr_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == '0) begin
            cnt <= div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = en && (cnt == '0);
endmodule

// File: rtl/i2c_wr_hold.sv
module i2c_wr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         flush,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

    // R11: a flush pulse always leaves the holding register empty
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !full);
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
    import i2c_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             hold_full,
    input  logic [REG_W-1:0] hold_data,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             start_taken,
    output logic             stop_done,
    output logic             load,
    output logic             first_out,
    output logic             ack_set,
    output logic             nack_set
);
    localparam int BIT_W = $clog2(REG_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_W - 1);

    eng_state_t       state, state_n;
    logic [1:0]       q, q_n;
    logic [BIT_W-1:0] bitn, bitn_n;
    logic [REG_W-1:0] sh, sh_n;
    logic             ack_low, ack_low_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            q       <= '0;
            bitn    <= '0;
            sh      <= '0;
            ack_low <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            q     <= '0;
            bitn  <= '0;
        end else begin
            state   <= state_n;
            q       <= q_n;
            bitn    <= bitn_n;
            sh      <= sh_n;
            ack_low <= ack_low_n;
        end
    end

    always_comb begin
        state_n     = state;
        q_n         = q;
        bitn_n      = bitn;
        sh_n        = sh;
        ack_low_n   = ack_low;
        start_taken = 1'b0;
        stop_done   = 1'b0;
        load        = 1'b0;
        first_out   = 1'b0;
        ack_set     = 1'b0;
        nack_set    = 1'b0;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (stop_req) begin
                        stop_done = 1'b1;
                    end else if (start_req && hold_full) begin
                        state_n = ST_START;
                        q_n     = '0;
                    end
                end
                ST_START: begin
                    if (q == 2'd2) begin
                        state_n     = ST_DATA;
                        q_n         = '0;
                        bitn_n      = '0;
                        sh_n        = hold_data;
                        load        = 1'b1;
                        start_taken = 1'b1;
                    end else begin
                        q_n = q + 2'd1;
                    end
                end
                ST_DATA: begin
                    if (q == 2'd3) begin
                        q_n  = '0;
                        sh_n = {sh[REG_W-2:0], 1'b0};
                        if (bitn == '0) first_out = 1'b1;
                        if (bitn == LAST_BIT) begin
                            state_n = ST_ACK;
                        end else begin
                            bitn_n = bitn + 1'b1;
                        end
                    end else begin
                        q_n = q + 2'd1;
                    end
                end
                ST_ACK: begin
                    if (q == 2'd1) ack_low_n = !sda_in;
                    if (q == 2'd3) begin
                        q_n = '0;
                        if (ack_low) begin
                            ack_set = 1'b1;
                            if (stop_req) begin
                                state_n = ST_STOP;
                            end else if (hold_full) begin
                                state_n = ST_DATA;
                                bitn_n  = '0;
                                sh_n    = hold_data;
                                load    = 1'b1;
                            end else begin
                                state_n = ST_HOLD;
                            end
                        end else begin
                            nack_set = 1'b1;
                            state_n  = ST_NACK;
                        end
                    end else begin
                        q_n = q + 2'd1;
                    end
                end
                ST_HOLD: begin
                    q_n = '0;
                    if (stop_req) begin
                        state_n = ST_STOP;
                    end else if (hold_full) begin
                        state_n = ST_DATA;
                        bitn_n  = '0;
                        sh_n    = hold_data;
                        load    = 1'b1;
                    end
                end
                ST_NACK: begin
                    q_n = '0;
                    if (stop_req) state_n = ST_STOP;
                end
                ST_STOP: begin
                    if (q == 2'd2) begin
                        state_n   = ST_IDLE;
                        q_n       = '0;
                        stop_done = 1'b1;
                    end else begin
                        q_n = q + 2'd1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            ST_START: begin
                scl_oe = (q == 2'd2);
                sda_oe = (q != 2'd0);
            end
            ST_DATA: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = !sh[REG_W-1];
            end
            ST_ACK: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = 1'b0;
            end
            ST_HOLD, ST_NACK: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_STOP: begin
                scl_oe = (q == 2'd0);
                sda_oe = (q != 2'd2);
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    // R4: with SCL released on both edges, SDA moves only for START/STOP
    assert_sda_low_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && !$stable(sda_oe))
        |-> (state == ST_START || state == ST_STOP || state == ST_IDLE));

    // R6: the shift register is only loaded from a full holding register
    assert_load_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> hold_full);

    // R7: after a NACK the engine waits for a STOP request
    assert_nack_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NACK && !stop_req && en) |=> (state == ST_NACK || !en));

    // R9: a byte always finishes with its acknowledge clock
    assert_stop_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(state) == ST_DATA && state != ST_DATA)
        |-> state == ST_ACK);
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
    import i2c_wr_pkg::*;
#(
    parameter int DIV_RESET = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             scl_oe,
    input  logic             scl_in,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int DIV_W = REG_W;

    logic             en_q, txie_q, start_q, stop_q, flush_q, ack_q, nack_q;
    logic [DIV_W-1:0] div_q;
    logic             tick, hold_full, tdre;
    logic [REG_W-1:0] hold_data;
    logic             start_taken, stop_done, load, first_out, ack_set, nack_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            txie_q  <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            flush_q <= 1'b0;
            ack_q   <= 1'b0;
            nack_q  <= 1'b0;
            div_q   <= DIV_W'(DIV_RESET);
        end else begin
            flush_q <= 1'b0;
            if (start_taken) start_q <= 1'b0;
            if (stop_done) begin
                stop_q <= 1'b0;
                nack_q <= 1'b0;
            end
            if (ack_set) ack_q <= 1'b1;
            if (nack_set) begin
                ack_q  <= 1'b0;
                nack_q <= 1'b1;
            end
            if (reg_we && reg_addr == A_CTRL) begin
                en_q    <= reg_wdata[C_EN];
                txie_q  <= reg_wdata[C_TXIE];
                start_q <= reg_wdata[C_START];
                stop_q  <= reg_wdata[C_STOP];
                flush_q <= reg_wdata[C_FLUSH];
            end
            if (reg_we && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    assign tdre = !hold_full;
    assign irq  = en_q && ((txie_q && tdre) || nack_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_EN]    = en_q;
                reg_rdata[C_TXIE]  = txie_q;
                reg_rdata[C_START] = start_q;
                reg_rdata[C_STOP]  = stop_q;
                reg_rdata[C_FLUSH] = flush_q;
            end
            A_STAT: begin
                reg_rdata[S_TDRE] = tdre;
                reg_rdata[S_ACK]  = ack_q;
                reg_rdata[S_NACK] = nack_q;
            end
            A_DATA:  reg_rdata = hold_data;
            A_DIV:   reg_rdata = div_q;
            default: reg_rdata = '0;
        endcase
    end

    i2c_wr_tick #(.W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_q),
        .div  (div_q),
        .tick (tick)
    );

    i2c_wr_hold #(.W(REG_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_we && reg_addr == A_DATA),
        .wdata(reg_wdata),
        .flush(flush_q),
        .drain(first_out),
        .full (hold_full),
        .data (hold_data)
    );

    i2c_wr_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .tick       (tick),
        .start_req  (start_q),
        .stop_req   (stop_q),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .sda_in     (sda_in),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .start_taken(start_taken),
        .stop_done  (stop_done),
        .load       (load),
        .first_out  (first_out),
        .ack_set    (ack_set),
        .nack_set   (nack_set)
    );

    // R4: whenever this block pulls SCL, the line reads low
    assert_scl_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !scl_in);
endmodule

// File: tb/i2c_wr_master_bench.sv
`timescale 1ns/1ps
module i2c_wr_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slv_pull = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_pull);

    always #2 clk = ~clk;

    i2c_wr_master u_i2c_wr_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq),
        .scl_oe   (scl_oe),
        .scl_in   (scl_line),
        .sda_oe   (sda_oe),
        .sda_in   (sda_line)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int bitc = 0, nbytes = 0, starts = 0, stops = 0, stop_bytes = 0;
    int ack_limit = 99, exp_period = 16, last_rise = 0;
    logic in_ack = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] sh = 8'd0;
    logic [7:0] rx [0:7];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // slave model and watchdog; line values are the pre-edge ones
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            starts++;
            bitc = 0;
            nbytes = 0;
            in_ack = 1'b0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            stops++;
            stop_bytes = nbytes;
        end
        if (scl_line && !prev_scl && !in_ack) begin
            if (bitc > 0 && bitc < 8) chk("R4 scl period", cyc - last_rise, exp_period);
            last_rise = cyc;
            sh = {sh[6:0], sda_line};
            bitc++;
            if (bitc == 8) begin
                rx[nbytes % 8] = sh;
                nbytes++;
            end
        end
        if (!scl_line && prev_scl) begin
            if (in_ack) begin
                in_ack = 1'b0;
                bitc = 0;
                slv_pull <= 1'b0;
            end else if (bitc == 8) begin
                in_ack = 1'b1;
                slv_pull <= ((nbytes - 1) < ack_limit);
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [1:0] a, input int b, input logic v);
        logic [7:0] s;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            rd(a, s);
            if (s[b] == v) break;
        end
    endtask

    task automatic make_bytes(input int dv, input int n, output logic [7:0] b [0:3]);
        b[0] = {7'(7'h28 + dv + n), 1'b0};
        for (int i = 1; i < 4; i++) b[i] = 8'(i * 73 + dv * 29 + n * 11 + 92);
    endtask

    task automatic run_ok(input int dv, input int n, input bit slow);
        logic [7:0] b [0:3];
        logic [7:0] s;
        int s0, st0;
        make_bytes(dv, n, b);
        ack_limit = 99;
        exp_period = 4 * (dv + 1);
        wr(2'd3, 8'(dv));
        wr(2'd0, 8'h03);
        s0 = starts;
        st0 = stops;
        wr(2'd2, b[0]);
        wr(2'd0, 8'h07);
        for (int i = 1; i <= n; i++) begin
            wait_bit(2'd1, 0, 1'b1);
            chk("R5 tdre after first bit", bitc, 1);
            if (slow && i == 1) begin
                repeat (300) @(negedge clk);
                chk("R10 scl held low", scl_oe, 1);
                chk("R10 bytes while waiting", nbytes, 1);
                chk("R10 no stop while waiting", stops, st0);
            end
            wr(2'd2, b[i]);
        end
        wait_bit(2'd1, 0, 1'b1);
        chk("R5 tdre after first bit", bitc, 1);
        wr(2'd0, 8'h0B);
        wait_bit(2'd0, 3, 1'b0);
        chk("R3 one start", starts, s0 + 1);
        chk("R9 one stop", stops, st0 + 1);
        chk("R9 stop after last ack", stop_bytes, n + 1);
        for (int i = 0; i <= n; i++) chk("R4 byte on bus", rx[i], b[i]);
        rd(2'd1, s);
        chk("R6 status after acked transfer", s, 8'h03);
        rd(2'd0, s);
        chk("R3 start and stop self-cleared", s, 8'h03);
        chk("R4 lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic run_nack(input int k, input int dv);
        logic [7:0] b [0:3];
        logic [7:0] s;
        int st0;
        make_bytes(dv, k, b);
        ack_limit = k;
        exp_period = 4 * (dv + 1);
        wr(2'd3, 8'(dv));
        wr(2'd0, 8'h03);
        st0 = stops;
        wr(2'd2, b[0]);
        wr(2'd0, 8'h07);
        for (int i = 1; i <= k + 1; i++) begin
            wait_bit(2'd1, 0, 1'b1);
            wr(2'd2, b[i]);
        end
        wait_bit(2'd1, 2, 1'b1);
        rd(2'd1, s);
        chk("R7 status on nack", s, 8'h04);
        chk("R7 irq on nack", irq, 1);
        repeat (40) @(negedge clk);
        chk("R7 scl held after nack", scl_oe, 1);
        chk("R7 no stop before request", stops, st0);
        chk("R7 bytes before nack", nbytes, k + 1);
        wr(2'd0, 8'h19);
        rd(2'd0, s);
        chk("R8 flush reads back set", s, 8'h19);
        @(negedge clk);
        rd(2'd1, s);
        chk("R8 flush empties data register", s[0], 1);
        wait_bit(2'd0, 3, 1'b0);
        rd(2'd1, s);
        chk("R8 nack cleared by stop", s, 8'h01);
        rd(2'd0, s);
        chk("R8 control after recovery", s, 8'h01);
        chk("R8 stop sent", stops, st0 + 1);
        chk("R8 stop after nacked byte", stop_bytes, k + 1);
        chk("R2 irq quiet after recovery", irq, 0);
        for (int i = 0; i <= k; i++) chk("R4 byte before nack", rx[i], b[i]);
    endtask

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, s);
        chk("R1 control reset", s, 8'h00);
        rd(2'd1, s);
        chk("R1 status reset", s, 8'h01);
        chk("R1 lines released", {scl_oe, sda_oe}, 0);
        chk("R1 irq reset", irq, 0);

        wr(2'd0, 8'h01);
        chk("R2 irq without txie", irq, 0);
        wr(2'd0, 8'h03);
        chk("R2 irq with txie and tdre", irq, 1);
        wr(2'd2, 8'hA5);
        chk("R2 irq after data write", irq, 0);
        rd(2'd1, s);
        chk("R2 tdre cleared by write", s, 8'h00);

        wr(2'd0, 8'h13);
        rd(2'd0, s);
        chk("R8 flush bit one cycle", s, 8'h13);
        @(negedge clk);
        rd(2'd1, s);
        chk("R11 flush sets tdre", s, 8'h01);
        rd(2'd0, s);
        chk("R8 flush bit self-clears", s, 8'h03);
        wr(2'd0, 8'h07);
        repeat (100) @(negedge clk);
        chk("R11 no start after flush", starts, 0);
        rd(2'd0, s);
        chk("R3 start pending without data", s, 8'h07);
        wr(2'd0, 8'h03);

        for (int dv = 0; dv < 3; dv++) begin
            for (int n = 0; n < 3; n++) begin
                run_ok(dv, n, (dv == 1 && n == 1));
            end
        end
        run_nack(0, 1);
        run_nack(1, 0);
        run_ok(2, 2, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule